// File: doc/BRIEF.md
# Configurable I2S Transmit Serializer

This block turns queued stereo audio sample pairs into a serial data stream with a matching word-select line. Sample pairs enter a small internal queue through a push port. Each frame of `2*SAMPLE_W` bit-clock ticks takes one pair from the queue. The left slot goes out while the logical channel is left, and the right slot follows. The bit clock itself is generated elsewhere: the block advances only on cycles where `bclk_en` is high, and both serial outputs are registers that change only on those cycles.

A seven-bit control word is written through a small register port and selects the frame options:
- stereo, right-only or left-only output;
- inversion of the sample's top bit;
- whether the first or the last sample bit leads;
- which level of word-select marks the right channel;
- whether data lags each word-select edge by one tick or lines up with it;
- whether an empty queue produces silence or a repeat of the last sample.

A written control word waits and is applied at the next frame start, so a frame never changes its format part-way through. When a frame begins with no sample queued, a sticky underflow flag is raised. Software clears it by writing a one to the status address.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, `sd_o` is 0, `ws_o` is 1, `underflow_o` is 0 and `push_ready` is 1. All control fields are 0, which selects stereo, no inversion, silence on underflow, first-bit-is-top-bit order, normal polarity and a one-tick delay.
- R2: Every frame is `2*SAMPLE_W` ticks long. The first tick after reset starts a frame. In the first half the channel is left, and in the second half it is right. With control 0, `ws_o` is 0 for left and 1 for right. The left word's top bit appears on the tick after the frame starts, and the right word's last bit appears on the first tick of the next frame.
- R3: Control bits [1:0] select the channel mode: 00 or 11 is stereo, 01 is right only, 10 is left only. In a single-channel mode the other slot carries all zeros, and `ws_o` keeps toggling every `SAMPLE_W` ticks.
- R4: When control bit 2 is set, the top bit of every transmitted sample is inverted. All other bits pass through unchanged.
- R5: When control bit 4 is set, each slot sends bit 0 first and the top bit last.
- R6: When control bit 5 is set, `ws_o` is 1 during the left half and 0 during the right half.
- R7: When control bit 6 is set, the first bit of each slot appears on the same tick as the word-select edge that opens that slot.
- R8: When a frame starts with the queue empty and control bit 3 is clear, both slots are all zeros and top-bit inversion is not applied. `underflow_o` rises on that tick and stays high.
- R9: When a frame starts with the queue empty and control bit 3 is set, the most recently dequeued pair is sent again, shaped by the current options.
- R10: A write with `cfg_addr`=1 and `cfg_wdata[0]`=1 clears `underflow_o`. A status write with bit 0 at 0 leaves it unchanged. If a clear and a new underflow fall in the same cycle, the new underflow wins.
- R11: A control write (`cfg_addr`=0) takes effect only at the next frame start. The frame already in progress keeps its old options.
- R12: `push_ready` is 0 while `FIFO_DEPTH` pairs are queued. A push made while it is 0 is dropped, and samples leave the queue in arrival order.
- R13: `sd_o` and `ws_o` change only on clock edges where `bclk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle pulse per serial bit period |
| push_valid | input | 1 | Enqueue the sample pair on this cycle |
| push_left | input | SAMPLE_W | Left sample to enqueue |
| push_right | input | SAMPLE_W | Right sample to enqueue |
| push_ready | output | 1 | Queue has room for a pair |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control word, 1 = status clear |
| cfg_wdata | input | 7 | Write data |
| sd_o | output | 1 | Serial data out |
| ws_o | output | 1 | Word-select out |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with `SAMPLE_W`=8 and `FIFO_DEPTH`=4. With 16-tick frames, a run that fills the queue, overflows it, drains it into an underflow frame and then repeats held samples stays within about a hundred ticks. The bench spaces `bclk_en` pulses one idle cycle apart, so a test can confirm that outputs do not move between ticks. The small depth means four pushes are enough to reach the full condition and the dropped fifth push.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    CH_BOTH  = 2'b00,
    CH_RIGHT = 2'b01,
    CH_LEFT  = 2'b10,
    CH_RSVD  = 2'b11
  } ch_mode_e;

  // Packed MSB-first: no_delay is bit 6, ch_mode occupies bits [1:0].
  typedef struct packed {
    logic     no_delay;
    logic     ws_swap;
    logic     lsb_first;
    logic     hold_on_empty;
    logic     sign_flip;
    ch_mode_e ch_mode;
  } tx_cfg_t;

  localparam int CFG_BITS = $bits(tx_cfg_t);

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    level;
  logic             do_wr, do_rd;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // Storage without reset so distributed or block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
  import i2s_tx_pkg::*;
#(
  parameter int W = 16
) (
  input  ch_mode_e       ch_mode,
  input  logic           sign_flip,
  input  logic           hold_on_empty,
  input  logic           lsb_first,
  input  logic           have_smp,
  input  logic [W-1:0]   new_l,
  input  logic [W-1:0]   new_r,
  input  logic [W-1:0]   held_l,
  input  logic [W-1:0]   held_r,
  output logic [W-1:0]   word_l,
  output logic [W-1:0]   word_r
);
  localparam logic [W-1:0] TOP_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] fresh   [2];
  logic [W-1:0] kept    [2];
  logic [W-1:0] pick    [2];
  logic [W-1:0] shaped  [2];
  logic [W-1:0] rev     [2];
  logic [W-1:0] ordered [2];
  logic         slot_on [2];
  logic         blank;

  assign fresh[0]   = new_l;
  assign fresh[1]   = new_r;
  assign kept[0]    = held_l;
  assign kept[1]    = held_r;
  assign slot_on[0] = (ch_mode != CH_RIGHT);
  assign slot_on[1] = (ch_mode != CH_LEFT);
  assign blank      = !have_smp && !hold_on_empty;

  for (genvar ch = 0; ch < 2; ch++) begin : g_slot
    assign pick[ch]   = have_smp ? fresh[ch] : kept[ch];
    assign shaped[ch] = (blank || !slot_on[ch]) ? '0
                      : (pick[ch] ^ (sign_flip ? TOP_MASK : '0));
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign rev[ch][b] = shaped[ch][W-1-b];
    end
    // Stored in transmit order: bit W-1 leaves first.
    assign ordered[ch] = lsb_first ? rev[ch] : shaped[ch];
  end

  assign word_l = ordered[0];
  assign word_r = ordered[1];

endmodule

// File: rtl/i2s_tx_sequencer.sv
module i2s_tx_sequencer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         no_delay,
  input  logic         ws_swap,
  input  logic [W-1:0] new_l,
  input  logic [W-1:0] new_r,
  output logic         load,
  output logic         sd_o,
  output logic         ws_o
);
  localparam int FW = 2 * W;
  localparam int CW = $clog2(FW);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_POS  = CW'(FW - 1);
  localparam logic [CW-1:0] HALF_POS  = CW'(W);
  localparam logic [CW-1:0] HALF_LAST = CW'(W - 1);

  logic [CW-1:0] cnt, cnt_nx, d_idx;
  logic [W-1:0]  cur_l, cur_r, wl;
  logic [BW-1:0] bpos;
  logic          at_wrap, in_right_d, sd_nx, ws_nx;

  assign at_wrap = (cnt == LAST_POS);
  assign load    = tick && at_wrap;
  assign cnt_nx  = at_wrap ? '0 : cnt + 1'b1;

  always_comb begin
    if (no_delay)            d_idx = cnt_nx;
    else if (cnt_nx == '0)   d_idx = LAST_POS;
    else                     d_idx = cnt_nx - 1'b1;
    // At a frame start only the new left word or the old right word is read.
    wl         = at_wrap ? new_l : cur_l;
    in_right_d = (d_idx >= HALF_POS);
    bpos       = in_right_d ? BW'(LAST_POS - d_idx) : BW'(HALF_LAST - d_idx);
    sd_nx      = in_right_d ? cur_r[bpos] : wl[bpos];
    ws_nx      = (cnt_nx >= HALF_POS) ^ ws_swap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= LAST_POS;
      cur_l <= '0;
      cur_r <= '0;
      sd_o  <= 1'b0;
      ws_o  <= 1'b1;
    end else if (tick) begin
      cnt  <= cnt_nx;
      sd_o <= sd_nx;
      ws_o <= ws_nx;
      if (at_wrap) begin
        cur_l <= new_l;
        cur_r <= new_r;
      end
    end
  end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_en,
  input  logic                push_valid,
  input  logic [SAMPLE_W-1:0] push_left,
  input  logic [SAMPLE_W-1:0] push_right,
  output logic                push_ready,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [CFG_BITS-1:0] cfg_wdata,
  output logic                sd_o,
  output logic                ws_o,
  output logic                underflow_o
);
  localparam int PAIR_W = 2 * SAMPLE_W;

  tx_cfg_t             cfg_pend, cfg_act, cfg_eff;
  logic [PAIR_W-1:0]   head;
  logic [SAMPLE_W-1:0] held_l, held_r, word_l, word_r;
  logic                full, empty, load, clr_req;

  i2s_tx_fifo #(.WIDTH(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_valid),
    .wr_data ({push_left, push_right}),
    .rd_en   (load),
    .rd_data (head),
    .full    (full),
    .empty   (empty)
  );

  assign push_ready = !full;
  assign cfg_eff    = load ? cfg_pend : cfg_act;
  assign clr_req    = cfg_we && cfg_addr && cfg_wdata[0];

  i2s_tx_framer #(.W(SAMPLE_W)) u_framer (
    .ch_mode       (cfg_eff.ch_mode),
    .sign_flip     (cfg_eff.sign_flip),
    .hold_on_empty (cfg_eff.hold_on_empty),
    .lsb_first     (cfg_eff.lsb_first),
    .have_smp      (!empty),
    .new_l         (head[PAIR_W-1:SAMPLE_W]),
    .new_r         (head[SAMPLE_W-1:0]),
    .held_l        (held_l),
    .held_r        (held_r),
    .word_l        (word_l),
    .word_r        (word_r)
  );

  i2s_tx_sequencer #(.W(SAMPLE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (bclk_en),
    .no_delay (cfg_eff.no_delay),
    .ws_swap  (cfg_eff.ws_swap),
    .new_l    (word_l),
    .new_r    (word_r),
    .load     (load),
    .sd_o     (sd_o),
    .ws_o     (ws_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pend    <= '0;
      cfg_act     <= '0;
      held_l      <= '0;
      held_r      <= '0;
      underflow_o <= 1'b0;
    end else begin
      if (cfg_we && !cfg_addr) cfg_pend <= tx_cfg_t'(cfg_wdata);
      if (load) cfg_act <= cfg_pend;
      if (load && !empty) begin
        held_l <= head[PAIR_W-1:SAMPLE_W];
        held_r <= head[SAMPLE_W-1:0];
      end
      if (load && empty) underflow_o <= 1'b1;
      else if (clr_req)  underflow_o <= 1'b0;
    end
  end

endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk
  import i2s_tx_pkg::*;
#(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                bclk_en,
  input logic                cfg_we,
  input logic                cfg_addr,
  input logic [CFG_BITS-1:0] cfg_wdata,
  input logic                push_ready,
  input logic                sd_o,
  input logic                ws_o,
  input logic                underflow_o
);
  logic        ws_q, tick_q, armed;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    ws_q <= ws_o;
    if (rst) begin
      tick_q <= 1'b0;
      armed  <= 1'b0;
      run    <= '0;
    end else begin
      tick_q <= bclk_en;
      if (tick_q) begin
        if (ws_o != ws_q) begin
          run   <= 16'd1;
          armed <= 1'b1;
        end else begin
          run <= run + 16'd1;
        end
      end
    end
  end

  // R13: serial outputs move only on enabled ticks
  a_r13_quiet_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !bclk_en |=> ($stable(sd_o) && $stable(ws_o)));

  // R2: word-select half period is exactly W ticks
  a_r2_ws_half_period: assert property (@(posedge clk) disable iff (rst)
    (tick_q && armed && (ws_o != ws_q)) |-> (run == 16'(W)));

  // R8: underflow flag is sticky until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && !(cfg_we && cfg_addr && cfg_wdata[0])) |=> underflow_o);

  // R10: a clear with no frame start drops the flag
  a_r10_clear_works: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr && cfg_wdata[0] && !bclk_en) |=> !underflow_o);

  // R12: a full queue stays full when nothing can drain it
  a_r12_full_holds: assert property (@(posedge clk) disable iff (rst)
    (!push_ready && !bclk_en) |=> !push_ready);

endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk #(.W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bclk_en     (bclk_en),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .push_ready  (push_ready),
  .sd_o        (sd_o),
  .ws_o        (ws_o),
  .underflow_o (underflow_o)
);

// File: tb/i2s_tx_serializer_tb.sv
`timescale 1ns/1ps
module i2s_tx_serializer_tb;
  localparam int W    = 8;
  localparam int D    = 4;
  localparam int FW   = 2 * W;
  localparam int LOGN = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk_en = 1'b0;
  logic         push_valid = 1'b0;
  logic [W-1:0] push_left = '0, push_right = '0;
  logic         push_ready;
  logic         cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [6:0]   cfg_wdata = '0;
  logic         sd_o, ws_o, underflow_o;

  int checks = 0;
  int errors = 0;
  int t = 0;
  logic ws_log [LOGN];
  logic sd_log [LOGN];

  always #2.5 clk = ~clk;

  i2s_tx_serializer #(.SAMPLE_W(W), .FIFO_DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .bclk_en(bclk_en),
    .push_valid(push_valid), .push_left(push_left), .push_right(push_right),
    .push_ready(push_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sd_o(sd_o), .ws_o(ws_o), .underflow_o(underflow_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] txw(input logic [W-1:0] raw, input bit sgn, input bit lsb);
    logic [W-1:0] v, r;
    v = sgn ? (raw ^ {1'b1, {(W-1){1'b0}}}) : raw;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return lsb ? r : v;
  endfunction

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; bclk_en = 0; push_valid = 0; cfg_we = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; t = 0;
  endtask

  task automatic write_cfg(input logic [6:0] v);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic write_status(input logic b);
    cfg_we = 1; cfg_addr = 1; cfg_wdata = {6'd0, b};
    @(negedge clk);
    cfg_we = 0; cfg_addr = 0;
  endtask

  task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
    push_valid = 1; push_left = l; push_right = r;
    @(negedge clk);
    push_valid = 0;
  endtask

  // One tick followed by an idle cycle; R13 is checked across the idle cycle.
  task automatic tick();
    logic s_ws, s_sd;
    bclk_en = 1;
    @(negedge clk);
    bclk_en = 0;
    s_ws = ws_o; s_sd = sd_o;
    if (t < LOGN) begin ws_log[t] = ws_o; sd_log[t] = sd_o; end
    @(negedge clk);
    if ((ws_o != s_ws) || (sd_o != s_sd)) begin
      errors++;
      $display("FAIL R13: actual=0x%0h expected=0x%0h", {ws_o, sd_o}, {s_ws, s_sd});
    end
    t++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check_frame(input int f, input logic [W-1:0] el, input logic [W-1:0] er,
                             input bit dly, input bit swp, input string req);
    logic [W-1:0]  al, ar;
    logic [FW-1:0] aws, ews;
    int base, off;
    base = f * FW;
    off  = dly ? 1 : 0;
    for (int k = 0; k < W; k++) begin
      al[W-1-k] = sd_log[base + k + off];
      ar[W-1-k] = sd_log[base + W + k + off];
    end
    for (int i = 0; i < FW; i++) begin
      aws[i] = ws_log[base + i];
      ews[i] = (i >= W) ? !swp : swp;
    end
    chk(al == el, {req, " left slot"}, 32'(al), 32'(el));
    chk(ar == er, {req, " right slot"}, 32'(ar), 32'(er));
    chk(aws == ews, {req, " ws pattern"}, 32'(aws), 32'(ews));
  endtask

  task automatic test_reset();
    reset_dut();
    chk(sd_o == 0, "R1 sd", 32'(sd_o), 0);
    chk(ws_o == 1, "R1 ws", 32'(ws_o), 1);
    chk(underflow_o == 0, "R1 underflow", 32'(underflow_o), 0);
    chk(push_ready == 1, "R1 ready", 32'(push_ready), 1);
  endtask

  task automatic test_stereo();
    reset_dut();
    push(8'hA5, 8'h3C); push(8'h81, 8'h7E);
    run(2 * FW + 1);
    check_frame(0, 8'hA5, 8'h3C, 1, 0, "R2 frame0");
    check_frame(1, 8'h81, 8'h7E, 1, 0, "R2 frame1");
    chk(sd_log[0] == 0, "R2 first tick idle", 32'(sd_log[0]), 0);
  endtask

  task automatic test_mono();
    reset_dut();
    write_cfg(7'h01);
    push(8'hC3, 8'h5A);
    run(FW + 1);
    check_frame(0, 8'h00, 8'h5A, 1, 0, "R3 right only");
    reset_dut();
    write_cfg(7'h02);
    push(8'hC3, 8'h5A);
    run(FW + 1);
    check_frame(0, 8'hC3, 8'h00, 1, 0, "R3 left only");
  endtask

  task automatic test_sign();
    reset_dut();
    write_cfg(7'h04);
    push(8'h12, 8'hF0);
    run(FW + 1);
    check_frame(0, txw(8'h12, 1, 0), txw(8'hF0, 1, 0), 1, 0, "R4 sign flip");
  endtask

  task automatic test_lsb();
    reset_dut();
    write_cfg(7'h10);
    push(8'h13, 8'hE8);
    run(FW + 1);
    check_frame(0, txw(8'h13, 0, 1), txw(8'hE8, 0, 1), 1, 0, "R5 lsb first");
  endtask

  task automatic test_swap();
    reset_dut();
    write_cfg(7'h20);
    push(8'h69, 8'h96);
    run(FW + 1);
    check_frame(0, 8'h69, 8'h96, 1, 1, "R6 ws swap");
  endtask

  task automatic test_nodelay();
    reset_dut();
    write_cfg(7'h40);
    push(8'hB1, 8'h4E); push(8'h0F, 8'hF1);
    run(2 * FW);
    check_frame(0, 8'hB1, 8'h4E, 0, 0, "R7 frame0");
    check_frame(1, 8'h0F, 8'hF1, 0, 0, "R7 frame1");
  endtask

  task automatic test_underflow_zero();
    reset_dut();
    write_cfg(7'h04);
    push(8'h55, 8'h33);
    run(FW);
    chk(underflow_o == 0, "R8 flag before empty frame", 32'(underflow_o), 0);
    run(1);
    chk(underflow_o == 1, "R8 flag on empty frame", 32'(underflow_o), 1);
    run(FW);
    check_frame(0, txw(8'h55, 1, 0), txw(8'h33, 1, 0), 1, 0, "R8 last real frame");
    check_frame(1, 8'h00, 8'h00, 1, 0, "R8 silent frame");
    chk(underflow_o == 1, "R8 flag stays", 32'(underflow_o), 1);
    write_status(1'b0);
    chk(underflow_o == 1, "R10 zero write ignored", 32'(underflow_o), 1);
    write_status(1'b1);
    chk(underflow_o == 0, "R10 clear", 32'(underflow_o), 0);
  endtask

  task automatic test_hold();
    reset_dut();
    write_cfg(7'h0C);
    push(8'h2D, 8'hD2);
    run(3 * FW + 1);
    check_frame(1, txw(8'h2D, 1, 0), txw(8'hD2, 1, 0), 1, 0, "R9 hold frame1");
    check_frame(2, txw(8'h2D, 1, 0), txw(8'hD2, 1, 0), 1, 0, "R9 hold frame2");
    chk(underflow_o == 1, "R9 flag", 32'(underflow_o), 1);
  endtask

  task automatic test_boundary();
    reset_dut();
    push(8'h44, 8'h22); push(8'h11, 8'h77);
    run(5);
    write_cfg(7'h04);
    run(2 * FW + 1 - 5);
    check_frame(0, 8'h44, 8'h22, 1, 0, "R11 frame in flight");
    check_frame(1, txw(8'h11, 1, 0), txw(8'h77, 1, 0), 1, 0, "R11 next frame");
  endtask

  task automatic test_full();
    reset_dut();
    for (int i = 0; i < D; i++) push(8'(8'h10 + i), 8'(8'hE0 + i));
    chk(push_ready == 0, "R12 full", 32'(push_ready), 0);
    push(8'hFF, 8'hFF);
    run(1);
    chk(push_ready == 1, "R12 room after pop", 32'(push_ready), 1);
    run((D + 1) * FW);
    for (int i = 0; i < D; i++)
      check_frame(i, 8'(8'h10 + i), 8'(8'hE0 + i), 1, 0, "R12 order");
    check_frame(D, 8'h00, 8'h00, 1, 0, "R12 dropped push absent");
  endtask

  initial begin
    test_reset();
    test_stereo();
    test_mono();
    test_sign();
    test_lsb();
    test_swap();
    test_nodelay();
    test_underflow_zero();
    test_hold();
    test_boundary();
    test_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule